// File: doc/BRIEF.md
# Triple-Redundant SPI Configuration Register Bank

This block sits beside the readout logic of a multi-channel timestamping chip and gives an SPI master access to its configuration. A control register sets how many 16-bit words each timestamp occupies and where the readout clock comes from. Two status registers collect per-channel FIFO-full events as sticky flags. The reset values already describe a working setup, so the chip runs from power-up with no SPI traffic at all.

Every configuration bit and every status flag is kept in three flip-flops. A bitwise majority of the three drives both the chip and the read path. Each clock cycle all three copies are reloaded from that majority, so one copy hit by an upset is repaired on the next edge and never reaches an output. The sequencer that frames SPI transfers stores its phase and bit count the same way.

The SPI pins are asynchronous to `clk`. They are resynchronised and edge-detected, so SCLK must run well below the system clock: each SCLK half period has to span several `clk` cycles.

Top module: `ts_cfg_spi_tmr`

## Requirements
- R1: A frame is 16 bits, MSB first, SPI mode 0 (MOSI sampled on SCLK rising edges while CS_N is low). Bit 15 is the direction (1 = read, 0 = write), bits 14:8 are the register address and bits 7:0 are the data. A write takes effect once the 16th bit has been received.
- R2: After reset, the timestamp length code is 2'b01 (two words) and the readout clock select is 0 (internal clock). Reading address 0x01 returns 0x01.
- R3: The control register sits at address 0x01. Bits 1:0 hold the length code (00 = 1 word, 01 = 2, 10 = 3, 11 = 4) and appear on `ts_len_code`. Bit 2 selects the external readout clock when 1 and appears on `rdclk_ext_sel`. Bits 7:3 read as 0 and ignore writes. The register changes only on a completed write frame to its address.
- R4: In a read frame, MISO is 0 during the 8 header bits. The addressed register's value is then presented MSB first over the 8 data bits, each bit stable before the SCLK rising edge on which it is sampled.
- R5: One `clk` cycle with `fifo_full_in[i]` high sets flag i, and the flag stays set. Address 0x02 returns channels 7:0 and address 0x03 returns channels 15:8, with bit j of each holding the lowest channel of that register plus j.
- R6: Reading a status register clears its flags, except a channel whose input is high when the clear happens, which stays set. Writes to the status registers are ignored.
- R7: Writes to any address other than 0x01 leave all registers unchanged. Reads from addresses other than 0x01, 0x02 and 0x03 return 0.
- R8: A frame ended by CS_N rising before its 16th bit has no effect. Bits clocked after the 16th, while CS_N is still low, are ignored.
- R9: Each control and status bit is held in three copies with a majority-voted output. All copies reload from the vote every cycle, so corrupting one copy changes no output and is repaired within one cycle. Two copies corrupted one after the other, some cycles apart, also leave the value intact.
- R10: The frame sequencer's phase and bit counter are held in three voted copies with the same per-cycle repair.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sclk | input | 1 | SPI serial clock, asynchronous, idle low |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| fifo_full_in | input | NCH (16) | Per-channel FIFO-full indications, synchronous to clk |
| ts_len_code | output | 2 | Timestamp length code (word count minus one) |
| rdclk_ext_sel | output | 1 | Readout clock select, 1 = external |

## Verification
Each SPI pin edge passes two synchroniser flops and one edge-detect flop. The block therefore acts on an SCLK edge about three `clk` cycles after the pin moves, and register outputs change one edge after that. The bench holds every SCLK half period for eight `clk` cycles. It samples MISO just before raising SCLK, when the bit shifted on the previous falling edge has long settled. It reads the control outputs only after CS_N has gone high and an idle gap has passed. A FIFO-full input sets its flag on the next `clk` edge, and the read that follows comes many cycles later. Copy corruption is injected between edges, and the outputs are checked a few cycles after each upset.

// File: rtl/ts_cfg_pkg.sv
// Package: shared constants and types for the triple-redundant SPI register bank.
// Assumes 16-bit frames split into a direction bit, a 7-bit address and 8 data bits.
package ts_cfg_pkg;

    localparam int ADDR_W = 7;
    localparam int DATA_W = 8;
    localparam int CTRL_W = 3;

    localparam logic [ADDR_W-1:0] ADDR_CTRL  = 7'h01;
    localparam logic [ADDR_W-1:0] ADDR_STAT0 = 7'h02;

    // Default: two-word timestamps, internal readout clock.
    localparam logic [CTRL_W-1:0] CTRL_RST = 3'b001;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HDR  = 2'd1,
        PH_DATA = 2'd2,
        PH_TAIL = 2'd3
    } phase_t;

    typedef struct packed {
        phase_t     ph;
        logic [2:0] cnt;
    } seq_t;

    localparam int SEQ_W = $bits(seq_t);

endpackage

// File: rtl/tmr_vote_reg.sv
// Module: a W-bit register kept in three copies with a bitwise majority output.
// All copies load the same next value each cycle. The caller computes that value
// from q (the vote), so any single corrupted copy is overwritten on the next edge.
module tmr_vote_reg #(
    parameter int             W       = 1,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  d,
    output logic [W-1:0]  q
);

    logic [W-1:0] cp_a;
    logic [W-1:0] cp_b;
    logic [W-1:0] cp_c;

    // Load all three copies from the shared next value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cp_a <= RST_VAL;
            cp_b <= RST_VAL;
            cp_c <= RST_VAL;
        end else begin
            cp_a <= d;
            cp_b <= d;
            cp_c <= d;
        end
    end

    // Bitwise two-out-of-three majority.
    assign q = (cp_a & cp_b) | (cp_a & cp_c) | (cp_b & cp_c);

endmodule

// File: rtl/spi_pin_sync.sv
// Module: brings the asynchronous SPI pins into the clk domain and detects SCLK edges.
// Assumes each SCLK half period lasts well over STAGES+1 clk cycles.
module spi_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_pin,
    input  logic cs_n_pin,
    input  logic mosi_pin,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic sel,
    output logic din
);

    localparam int TOP = STAGES - 1;

    logic [STAGES-1:0] sclk_pipe;
    logic [STAGES-1:0] cs_pipe;
    logic [STAGES-1:0] mosi_pipe;
    logic              sclk_last;

    // Synchroniser chains plus one delayed SCLK sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_pipe <= '0;
            cs_pipe   <= '1;
            mosi_pipe <= '0;
            sclk_last <= 1'b0;
        end else begin
            sclk_pipe <= {sclk_pipe[STAGES-2:0], sclk_pin};
            cs_pipe   <= {cs_pipe[STAGES-2:0],   cs_n_pin};
            mosi_pipe <= {mosi_pipe[STAGES-2:0], mosi_pin};
            sclk_last <= sclk_pipe[TOP];
        end
    end

    // One-cycle edge pulses and resynchronised levels.
    assign sclk_rise =  sclk_pipe[TOP] & ~sclk_last;
    assign sclk_fall = ~sclk_pipe[TOP] &  sclk_last;
    assign sel       = ~cs_pipe[TOP];
    assign din       =  mosi_pipe[TOP];

endmodule

// File: rtl/spi_frame_ctl.sv
// Module: frames 16-bit SPI transfers: collects the header, raises a read strobe when
// the header is complete and a write strobe after the 16th bit, and shifts read data out.
// The phase and bit counter live in a voted triple register. The shift registers are
// plain flops, because every frame reloads them.
module spi_frame_ctl
    import ts_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              sel,
    input  logic              din,
    input  logic [DATA_W-1:0] rdata,
    output logic              miso,
    output logic              rd_fire,
    output logic              wr_fire,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] wdata
);

    seq_t              cur;
    seq_t              nxt;
    logic [SEQ_W-1:0]  cur_v;
    logic [DATA_W-2:0] hdr_sr;
    logic [DATA_W-2:0] dat_sr;
    logic [DATA_W-1:0] out_sr;
    logic [ADDR_W-1:0] addr_q;
    logic              is_read;
    logic [DATA_W-1:0] hdr_full;
    logic              hdr_done;
    logic              data_done;

    // Voted storage for the sequencer phase and bit count.
    tmr_vote_reg #(.W(SEQ_W), .RST_VAL('0)) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (nxt),
        .q     (cur_v)
    );

    assign cur       = seq_t'(cur_v);
    assign hdr_full  = {hdr_sr, din};
    assign hdr_done  = sel && sclk_rise && (cur.ph == PH_HDR)  && (cur.cnt == 3'd7);
    assign data_done = sel && sclk_rise && (cur.ph == PH_DATA) && (cur.cnt == 3'd7);

    // Next phase and count; CS high always returns to idle.
    always_comb begin
        nxt = cur;
        if (!sel) begin
            nxt = '{ph: PH_IDLE, cnt: 3'd0};
        end else begin
            case (cur.ph)
                PH_IDLE: nxt = '{ph: PH_HDR, cnt: 3'd0};
                PH_HDR: begin
                    if (sclk_rise) begin
                        if (cur.cnt == 3'd7) nxt = '{ph: PH_DATA, cnt: 3'd0};
                        else                 nxt.cnt = cur.cnt + 3'd1;
                    end
                end
                PH_DATA: begin
                    if (sclk_rise) begin
                        if (cur.cnt == 3'd7) nxt = '{ph: PH_TAIL, cnt: 3'd0};
                        else                 nxt.cnt = cur.cnt + 3'd1;
                    end
                end
                default: nxt = cur;
            endcase
        end
    end

    // Header and data shift-in, latched header fields, read-data shift-out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hdr_sr  <= '0;
            dat_sr  <= '0;
            out_sr  <= '0;
            addr_q  <= '0;
            is_read <= 1'b0;
        end else if (!sel) begin
            hdr_sr <= '0;
            dat_sr <= '0;
            out_sr <= '0;
        end else begin
            if (sclk_rise && cur.ph == PH_HDR)  hdr_sr <= hdr_full[DATA_W-2:0];
            if (sclk_rise && cur.ph == PH_DATA) dat_sr <= {dat_sr[DATA_W-3:0], din};
            if (hdr_done) begin
                addr_q  <= hdr_full[ADDR_W-1:0];
                is_read <= hdr_full[DATA_W-1];
                out_sr  <= hdr_full[DATA_W-1] ? rdata : '0;
            end else if (sclk_fall && cur.ph == PH_DATA && cur.cnt != 3'd0) begin
                out_sr <= {out_sr[DATA_W-2:0], 1'b0};
            end
        end
    end

    // Strobes and the address seen by the register file.
    assign addr    = (cur.ph == PH_HDR) ? hdr_full[ADDR_W-1:0] : addr_q;
    assign rd_fire = hdr_done && hdr_full[DATA_W-1];
    assign wr_fire = data_done && !is_read;
    assign wdata   = {dat_sr, din};
    assign miso    = out_sr[DATA_W-1];

endmodule

// File: rtl/ts_cfg_spi_tmr.sv
// Module: top of the configuration bank. It holds the voted control register (timestamp
// length and readout clock source) and the voted sticky FIFO-full flags, and serves them
// over SPI. Assumes fifo_full_in is synchronous to clk and NCH is at most 16.
module ts_cfg_spi_tmr
    import ts_cfg_pkg::*;
#(
    parameter int NCH         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           spi_sclk,
    input  logic           spi_cs_n,
    input  logic           spi_mosi,
    output logic           spi_miso,
    input  logic [NCH-1:0] fifo_full_in,
    output logic [1:0]     ts_len_code,
    output logic           rdclk_ext_sel
);

    localparam int NSTAT = (NCH + DATA_W - 1) / DATA_W;
    localparam int NPAD  = NSTAT * DATA_W;

    logic              sclk_rise;
    logic              sclk_fall;
    logic              sel;
    logic              din;
    logic              rd_fire;
    logic              wr_fire;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wdata;
    logic [DATA_W-1:0] rdata;
    logic [CTRL_W-1:0] ctrl_q;
    logic [CTRL_W-1:0] ctrl_d;
    logic [NCH-1:0]    flags_q;
    logic [NCH-1:0]    flags_d;
    logic [NPAD-1:0]   flags_pad;
    logic [NPAD-1:0]   clr_mask;
    logic              unused_wbits;

    spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_pin  (spi_sclk),
        .cs_n_pin  (spi_cs_n),
        .mosi_pin  (spi_mosi),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .sel       (sel),
        .din       (din)
    );

    spi_frame_ctl u_spi (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .sel       (sel),
        .din       (din),
        .rdata     (rdata),
        .miso      (spi_miso),
        .rd_fire   (rd_fire),
        .wr_fire   (wr_fire),
        .addr      (addr),
        .wdata     (wdata)
    );

    // Control register: a write to its address replaces it, otherwise it is refreshed from the vote.
    assign ctrl_d = (wr_fire && addr == ADDR_CTRL) ? wdata[CTRL_W-1:0] : ctrl_q;
    assign unused_wbits = ^wdata[DATA_W-1:CTRL_W];

    tmr_vote_reg #(.W(CTRL_W), .RST_VAL(CTRL_RST)) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (ctrl_d),
        .q     (ctrl_q)
    );

    // One clear-on-read mask byte per status register.
    genvar gk;
    generate
        for (gk = 0; gk < NSTAT; gk++) begin : g_clr
            localparam logic [ADDR_W-1:0] SADDR = ADDR_STAT0 + ADDR_W'(gk);
            assign clr_mask[gk*DATA_W +: DATA_W] =
                (rd_fire && addr == SADDR) ? {DATA_W{1'b1}} : {DATA_W{1'b0}};
        end
    endgenerate

    // Sticky flags: set by input, cleared by read, set wins.
    assign flags_d = (flags_q & ~clr_mask[NCH-1:0]) | fifo_full_in;

    tmr_vote_reg #(.W(NCH), .RST_VAL('0)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (flags_d),
        .q     (flags_q)
    );

    // Zero-extend the flags to whole bytes for the read mux.
    always_comb begin
        flags_pad = '0;
        flags_pad[NCH-1:0] = flags_q;
    end

    // Read mux: unmapped addresses return zero.
    always_comb begin
        rdata = '0;
        if (addr == ADDR_CTRL) rdata = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
        for (int k = 0; k < NSTAT; k++) begin
            if (addr == ADDR_STAT0 + ADDR_W'(k)) rdata = flags_pad[k*DATA_W +: DATA_W];
        end
    end

    assign ts_len_code   = ctrl_q[1:0];
    assign rdclk_ext_sel = ctrl_q[2];

endmodule

// File: rtl/ts_cfg_spi_tmr_chk.sv
// Checker: temporal properties of the register bank, bound into the top module.
module ts_cfg_spi_tmr_chk
    import ts_cfg_pkg::*;
#(
    parameter int NCH = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CTRL_W-1:0] cfg_a,
    input logic [CTRL_W-1:0] cfg_b,
    input logic [CTRL_W-1:0] cfg_c,
    input logic [SEQ_W-1:0]  seq_a,
    input logic [SEQ_W-1:0]  seq_b,
    input logic [SEQ_W-1:0]  seq_c,
    input logic [SEQ_W-1:0]  seq_v,
    input logic [CTRL_W-1:0] ctrl_q,
    input logic              wr_fire,
    input logic              rd_fire,
    input logic [ADDR_W-1:0] addr,
    input logic [NCH-1:0]    flags_q,
    input logic [NCH-1:0]    fifo_full_in,
    input logic              miso
);

    // Any disagreement among control copies is gone one cycle later.
    assert_cfg_scrub_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_a != cfg_b || cfg_b != cfg_c) |=> (cfg_a == cfg_b && cfg_b == cfg_c));

    // Same repair for the sequencer copies.
    assert_seq_scrub_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_a != seq_b || seq_b != seq_c) |=> (seq_a == seq_b && seq_b == seq_c));

    // Control value moves only on a write strobe.
    assert_ctrl_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_fire |=> $stable(ctrl_q));

    // A FIFO-full input sets its flag on the next edge.
    assert_flag_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|fifo_full_in) |=> ((flags_q & $past(fifo_full_in)) == $past(fifo_full_in)));

    // Reading the low status byte with no inputs active leaves it clear.
    assert_stat_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_fire && addr == ADDR_STAT0 && fifo_full_in[7:0] == 8'd0) |=> (flags_q[7:0] == 8'd0));

    // MISO stays low while the header is being collected.
    assert_miso_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_v[SEQ_W-1 -: 2] == PH_HDR) |-> !miso);

endmodule

bind ts_cfg_spi_tmr ts_cfg_spi_tmr_chk #(.NCH(NCH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_a        (u_cfg.cp_a),
    .cfg_b        (u_cfg.cp_b),
    .cfg_c        (u_cfg.cp_c),
    .seq_a        (u_spi.u_seq.cp_a),
    .seq_b        (u_spi.u_seq.cp_b),
    .seq_c        (u_spi.u_seq.cp_c),
    .seq_v        (u_spi.cur_v),
    .ctrl_q       (ctrl_q),
    .wr_fire      (wr_fire),
    .rd_fire      (rd_fire),
    .addr         (addr),
    .flags_q      (flags_q),
    .fifo_full_in (fifo_full_in),
    .miso         (spi_miso)
);

// File: tb/ts_cfg_spi_tmr_test.sv
// Bench: driver tasks push expected values into a queue, and a monitor pops and compares
// them against the values observed at the ports.
module ts_cfg_spi_tmr_test;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;
    localparam int NCH        = 16;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           spi_sclk;
    logic           spi_cs_n;
    logic           spi_mosi;
    logic           spi_miso;
    logic [NCH-1:0] fifo_full_in;
    logic [1:0]     ts_len_code;
    logic           rdclk_ext_sel;

    int    exp_q[$];
    string tag_q[$];
    int    obs_q[$];
    int    n_checks = 0;
    int    n_fail   = 0;
    bit    finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ts_cfg_spi_tmr #(.NCH(NCH)) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .spi_sclk      (spi_sclk),
        .spi_cs_n      (spi_cs_n),
        .spi_mosi      (spi_mosi),
        .spi_miso      (spi_miso),
        .fifo_full_in  (fifo_full_in),
        .ts_len_code   (ts_len_code),
        .rdclk_ext_sel (rdclk_ext_sel)
    );

    // Monitor: pair expected and observed items and compare them.
    always @(negedge clk) begin
        while (exp_q.size() > 0 && obs_q.size() > 0) begin
            int    e;
            int    o;
            string t;
            e = exp_q.pop_front();
            o = obs_q.pop_front();
            t = tag_q.pop_front();
            n_checks++;
            if (e != o) begin
                n_fail++;
                $display("FAIL %s: got 0x%0h expected 0x%0h", t, o, e);
            end
        end
    end

    task automatic check(input string tag, input int expected, input int observed);
        exp_q.push_back(expected);
        tag_q.push_back(tag);
        obs_q.push_back(observed);
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Drive one SPI frame of nbits; returns the 8 bits seen on MISO during the data phase.
    task automatic spi_frame(input logic rw, input logic [6:0] a, input logic [7:0] d,
                             input int nbits, output logic [7:0] rd);
        logic [15:0] word;
        word = {rw, a, d};
        rd = 8'h00;
        @(negedge clk);
        spi_cs_n = 1'b0;
        wait_clk(HALF);
        for (int i = 0; i < nbits; i++) begin
            spi_mosi = (i < 16) ? word[15-i] : 1'b1;
            wait_clk(HALF);
            if (i >= 8 && i < 16) rd = {rd[6:0], spi_miso};
            spi_sclk = 1'b1;
            wait_clk(HALF);
            spi_sclk = 1'b0;
        end
        wait_clk(HALF);
        spi_cs_n = 1'b1;
        spi_mosi = 1'b0;
        wait_clk(4*HALF);
    endtask

    task automatic rd_reg(input logic [6:0] a, output logic [7:0] v);
        spi_frame(1'b1, a, 8'h00, 16, v);
    endtask

    task automatic wr_reg(input logic [6:0] a, input logic [7:0] d);
        logic [7:0] dummy;
        spi_frame(1'b0, a, d, 16, dummy);
    endtask

    // Watchdog: an expired run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: got 0x0 expected 0x1 (run did not complete)");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        rst_n = 1'b0;
        spi_sclk = 1'b0;
        spi_cs_n = 1'b1;
        spi_mosi = 1'b0;
        fifo_full_in = '0;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);

        // R2 reset defaults, R4 MISO idle
        check("R2 len code after reset", 1, ts_len_code);
        check("R2 clock select after reset", 0, rdclk_ext_sel);
        check("R4 miso idle", 0, spi_miso);
        rd_reg(7'h01, v);
        check("R2 R4 control readback default", 8'h01, v);

        // R1 R3 write then read back
        wr_reg(7'h01, 8'h06);
        check("R3 len code after write", 2, ts_len_code);
        check("R3 clock select after write", 1, rdclk_ext_sel);
        rd_reg(7'h01, v);
        check("R1 control readback", 8'h06, v);

        // R3 reserved bits
        wr_reg(7'h01, 8'hFB);
        rd_reg(7'h01, v);
        check("R3 reserved bits read zero", 8'h03, v);
        check("R3 len code 4 words", 3, ts_len_code);
        check("R3 internal clock", 0, rdclk_ext_sel);

        // R7 unmapped addresses
        wr_reg(7'h35, 8'hFF);
        rd_reg(7'h01, v);
        check("R7 control untouched by unmapped write", 8'h03, v);
        rd_reg(7'h35, v);
        check("R7 unmapped read", 0, v);
        rd_reg(7'h00, v);
        check("R7 address zero read", 0, v);

        // R8 aborted and overlong frames
        spi_frame(1'b0, 7'h01, 8'h00, 12, v);
        check("R8 aborted write ignored", 3, ts_len_code);
        spi_frame(1'b0, 7'h01, 8'h05, 20, v);
        check("R8 overlong frame len", 1, ts_len_code);
        check("R8 overlong frame clock", 1, rdclk_ext_sel);

        // R5 sticky flags
        @(negedge clk);
        fifo_full_in = 16'h1008;
        @(negedge clk);
        fifo_full_in = '0;
        wait_clk(4);
        rd_reg(7'h02, v);
        check("R5 low status byte", 8'h08, v);
        rd_reg(7'h03, v);
        check("R5 high status byte", 8'h10, v);

        // R6 clear on read, set wins, writes ignored
        rd_reg(7'h02, v);
        check("R6 low byte cleared", 0, v);
        rd_reg(7'h03, v);
        check("R6 high byte cleared", 0, v);
        @(negedge clk);
        fifo_full_in = 16'h0001;
        rd_reg(7'h02, v);
        check("R6 held input read", 8'h01, v);
        @(negedge clk);
        fifo_full_in = '0;
        rd_reg(7'h02, v);
        check("R6 set wins over clear", 8'h01, v);
        rd_reg(7'h02, v);
        check("R6 cleared after release", 0, v);
        wr_reg(7'h03, 8'hFF);
        rd_reg(7'h03, v);
        check("R6 status write ignored", 0, v);

        // R9 upsets on two control copies, some cycles apart
        @(negedge clk);
        force uut.u_cfg.cp_a = 3'b010;
        #1;
        release uut.u_cfg.cp_a;
        wait_clk(3);
        check("R9 vote masks first upset", 1, ts_len_code);
        @(negedge clk);
        force uut.u_cfg.cp_b = 3'b010;
        #1;
        release uut.u_cfg.cp_b;
        wait_clk(3);
        check("R9 len after second upset", 1, ts_len_code);
        check("R9 clock after second upset", 1, rdclk_ext_sel);
        rd_reg(7'h01, v);
        check("R9 control readback after upsets", 8'h05, v);

        // R10 upsets on the sequencer copies
        @(negedge clk);
        force uut.u_spi.u_seq.cp_a = 5'b11111;
        #1;
        release uut.u_spi.u_seq.cp_a;
        wait_clk(3);
        @(negedge clk);
        force uut.u_spi.u_seq.cp_c = 5'b10111;
        #1;
        release uut.u_spi.u_seq.cp_c;
        wait_clk(3);
        rd_reg(7'h01, v);
        check("R10 frame after sequencer upsets", 8'h05, v);

        wait_clk(4);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule